// File: doc/BRIEF.md
# Two-Level Decoded ALU

This block is the arithmetic stage of a simple single-cycle processor datapath. A first decoding level, driven by the main instruction decoder, supplies a 2-bit class selector. That selector either forces an addition (used for load and store address arithmetic), forces a subtraction (used to test two registers for equality on a conditional branch), or hands the choice of operation over to the 6-bit function field taken from the low bits of a register-format instruction.

The second level turns that decision into a 4-bit operation code. The arithmetic unit then applies the code to two operands to produce a result and a flag that is high when the result is all zeros. Everything is combinational, and the operation code is brought out so that neighbouring logic and the bench can observe the decoded choice.

Top module: `alu_two_level`

## Requirements
- R1: With alu_op = 2'b00, op_code is 4'b0010 and result is src_a + src_b, whatever funct holds.
- R2: With alu_op = 2'b01, op_code is 4'b0110 and result is src_a - src_b, whatever funct holds.
- R3: With alu_op = 2'b10, funct 6'd32 gives add (op_code 0010), 6'd34 gives subtract (0110), 6'd36 gives bitwise AND (0000), 6'd37 gives bitwise OR (0001) and 6'd42 gives set-on-less-than (0111).
- R4: With alu_op = 2'b10, any funct value outside those five decodes to add (op_code 0010).
- R5: Set-on-less-than treats both operands as two's-complement signed values. The result is 1 in bit 0 when src_a < src_b and 0 otherwise, and all upper bits are zero.
- R6: zero is 1 exactly when every bit of result is 0.
- R7: Add and subtract wrap modulo 2^WIDTH and raise no other indication.
- R8: With alu_op = 2'b11, decoding is the same as with 2'b10. The upper selector bit alone hands control to funct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of a register-format instruction |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand |
| op_code | output | 4 | Decoded operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the block with its default WIDTH of 32. This puts the signed extremes 32'h8000_0000 and 32'h7FFF_FFFF within reach, so the tests can hit wrap-around on add and subtract and the set-on-less-than cases where an unsigned comparison would give the opposite answer. The bench also sweeps all 64 funct values under alu_op 2'b10 and 2'b11, which covers every code that must fall back to add.

// File: rtl/alu_two_level.sv
module alu_two_level #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       alu_op,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam logic [3:0] C_AND = 4'b0000;
  localparam logic [3:0] C_OR  = 4'b0001;
  localparam logic [3:0] C_ADD = 4'b0010;
  localparam logic [3:0] C_SUB = 4'b0110;
  localparam logic [3:0] C_SLT = 4'b0111;

  logic [3:0] fn_code;

  always_comb begin
    case (funct)
      6'd34:   fn_code = C_SUB;
      6'd36:   fn_code = C_AND;
      6'd37:   fn_code = C_OR;
      6'd42:   fn_code = C_SLT;
      default: fn_code = C_ADD;
    endcase
  end

  assign op_code = alu_op[1] ? fn_code : (alu_op[0] ? C_SUB : C_ADD);

  logic [WIDTH-1:0] diff;
  logic             less;
  assign diff = src_a - src_b;
  assign less = $signed(src_a) < $signed(src_b);

  always_comb begin
    case (op_code)
      C_AND:   result = src_a & src_b;
      C_OR:    result = src_a | src_b;
      C_SUB:   result = diff;
      C_SLT:   result = {{(WIDTH-1){1'b0}}, less};
      default: result = src_a + src_b;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/alu_two_level_chk.sv
module alu_two_level_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       alu_op,
  input logic [5:0]       funct,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] result,
  input logic             zero
);
  always_comb begin
    if (alu_op == 2'b00)
      p_force_add_r1: assert (op_code == 4'b0010 && result == src_a + src_b);
    if (alu_op == 2'b01)
      p_force_sub_r2: assert (op_code == 4'b0110 && result == src_a - src_b);
    if (alu_op[1] && funct == 6'd36)
      p_funct_and_r3: assert (result == (src_a & src_b));
    if (alu_op[1] && funct == 6'd37)
      p_funct_or_r3: assert (result == (src_a | src_b));
    if (op_code == 4'b0111)
      p_slt_narrow_r5: assert (result[WIDTH-1:1] == '0);
    p_zero_flag_r6: assert (zero == (result == '0));
  end
endmodule

bind alu_two_level alu_two_level_chk #(.WIDTH(WIDTH)) chk_i (
  .alu_op(alu_op), .funct(funct), .src_a(src_a), .src_b(src_b),
  .op_code(op_code), .result(result), .zero(zero)
);

// File: tb/alu_two_level_tb_top.sv
module alu_two_level_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   alu_op = 2'b00;
  logic [5:0]   funct = '0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic [3:0]   op_code;
  logic [W-1:0] result;
  logic         zero;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_two_level #(.WIDTH(W)) dut_i (
    .alu_op(alu_op), .funct(funct), .src_a(src_a), .src_b(src_b),
    .op_code(op_code), .result(result), .zero(zero)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [5:0] f,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    alu_op = op; funct = f; src_a = a; src_b = b;
    #1;
  endtask

  task automatic t_reset;
    chk("R6 reset zero", {31'd0, zero}, 1);
    chk("R1 reset code", {28'd0, op_code}, 32'h2);
    chk("R1 reset result", result, 0);
  endtask

  task automatic t_mem_add;
    apply(2'b00, 6'd34, 32'h1000, 32'hFFFF_FFFC);
    chk("R1 code", {28'd0, op_code}, 32'h2);
    chk("R1 result", result, 32'h0FFC);
    apply(2'b00, 6'd42, 32'd5, 32'd7);
    chk("R1 funct ignored", result, 32'd12);
  endtask

  task automatic t_branch_sub;
    apply(2'b01, 6'd36, 32'd77, 32'd77);
    chk("R2 code", {28'd0, op_code}, 32'h6);
    chk("R2 equal result", result, 0);
    chk("R6 zero on equal", {31'd0, zero}, 1);
    apply(2'b01, 6'd32, 32'd10, 32'd3);
    chk("R2 result", result, 32'd7);
    chk("R6 zero clear", {31'd0, zero}, 0);
  endtask

  task automatic t_funct(input logic [1:0] op, input string tag);
    logic [W-1:0] a = 32'hF0F0_1234, b = 32'h0FF0_0234;
    apply(op, 6'd32, a, b); chk({tag, " add"}, result, a + b);
    chk({tag, " add code"}, {28'd0, op_code}, 32'h2);
    apply(op, 6'd34, a, b); chk({tag, " sub"}, result, a - b);
    chk({tag, " sub code"}, {28'd0, op_code}, 32'h6);
    apply(op, 6'd36, a, b); chk({tag, " and"}, result, a & b);
    chk({tag, " and code"}, {28'd0, op_code}, 32'h0);
    apply(op, 6'd37, a, b); chk({tag, " or"}, result, a | b);
    chk({tag, " or code"}, {28'd0, op_code}, 32'h1);
    apply(op, 6'd42, a, b); chk({tag, " slt"}, result, 32'd1);
    chk({tag, " slt code"}, {28'd0, op_code}, 32'h7);
  endtask

  task automatic t_unknown(input logic [1:0] op);
    for (int f = 0; f < 64; f++) begin
      if (f != 34 && f != 36 && f != 37 && f != 42) begin
        apply(op, f[5:0], 32'd100, 32'd23);
        chk("R4 default add", result, 32'd123);
        chk("R4 default code", {28'd0, op_code}, 32'h2);
      end
    end
  endtask

  task automatic t_slt;
    apply(2'b10, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF);
    chk("R5 min<max", result, 1);
    apply(2'b10, 6'd42, 32'h7FFF_FFFF, 32'h8000_0000);
    chk("R5 max<min", result, 0);
    chk("R6 zero slt false", {31'd0, zero}, 1);
    apply(2'b10, 6'd42, 32'hFFFF_FFFF, 32'd0);
    chk("R5 -1<0", result, 1);
    apply(2'b10, 6'd42, 32'd9, 32'd9);
    chk("R5 equal", result, 0);
  endtask

  task automatic t_wrap;
    apply(2'b00, 6'd0, 32'hFFFF_FFFF, 32'd1);
    chk("R7 add wrap", result, 0);
    chk("R6 zero after wrap", {31'd0, zero}, 1);
    apply(2'b01, 6'd0, 32'h8000_0000, 32'd1);
    chk("R7 sub wrap", result, 32'h7FFF_FFFF);
    apply(2'b10, 6'd34, 32'd0, 32'd1);
    chk("R7 sub borrow", result, 32'hFFFF_FFFF);
  endtask

  initial begin
    #1;
    rst = 1'b0;
    t_reset();
    t_mem_add();
    t_branch_sub();
    t_funct(2'b10, "R3");
    t_funct(2'b11, "R8");
    t_unknown(2'b10);
    t_unknown(2'b11);
    t_slt();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule